// File: doc/BRIEF.md
# Quadrature Lowpass Sigma-Delta Upconverter with Chopping Multiplexers

The block turns a complex baseband sample stream into a three-level RF bitstream without running any arithmetic at the high rate. Two independent second-order lowpass sigma-delta loops quantize the in-phase and quadrature inputs to one bit (+1 or -1). The loops advance only when the baseband strobe `bb_stb` is high, so their clock rate is set by how often the caller raises it. Between strobes each loop holds its state and its output.

On the fast clock, a two-bit slot counter drives a multiplexer network. In the first stage each branch sign is either passed through or negated, which multiplies it by a carrier-rate square wave. The cosine carrier is the sequence 1, 0, -1, 0 and the sine carrier is 0, 1, 0, -1. A second stage interleaves the two chopped branches slot by slot. The loop signs are copied into a hold register once per four-slot carrier period, so the whole period uses one sign pair. As a result every carrier period contains both output polarities, even when the input is zero.

Top module: `sdmx_upconv`

## Requirements
- R1: `rf_sym` uses the code 2'b01 for +1, 2'b11 for -1 and 2'b00 for 0. Zero appears only during reset and before the first active edge. The code 2'b10 never appears.
- R2: The slot counter starts at 0 after reset and advances by one on every clock. The output registered from slot 0, 1, 2, 3 is +I, +Q, -I, -Q respectively, where I and Q are the held branch values. The first output after reset comes from slot 0.
- R3: Each loop has integrators a1 and a2 and the feedback v = +F when a2 >= 0 and v = -F otherwise, with F = 2^(IN_W-1). On a strobe the loop computes a1' = clip(a1 + x - v) and then a2' = clip(a2 + a1' - v). The branch value is +1 when a2 >= 0 and -1 otherwise.
- R4: The function clip limits each integrator to [-2^(AW-1), 2^(AW-1)-1], with AW = IN_W + ACC_GUARD. Integrators saturate at these limits and never wrap.
- R5: Without a strobe both integrators, and therefore both branch values, keep their values.
- R6: The hold register loads the two branch values only on the clock where the slot counter is 3. It loads the values from before any integrator update on that same clock. The first carrier period after reset uses +1 for both branches.
- R7: In every carrier period the slot-2 output is the opposite of the slot-0 output, and the slot-3 output is the opposite of the slot-1 output. This holds for any input, including zero.
- R8: Reset clears both integrators, the slot counter and the hold register, and drives `rf_sym` to 2'b00.
- R9: For a constant input x, the fraction of +1 values in a branch settles to (1 + x/F)/2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast (multiplexer-rate) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bb_stb | input | 1 | Baseband strobe; advances both sigma-delta loops |
| bb_i | input | IN_W | Signed in-phase baseband sample |
| bb_q | input | IN_W | Signed quadrature baseband sample |
| rf_sym | output | 2 | Three-level RF symbol (01 = +1, 11 = -1, 00 = 0) |

## Verification
The case of interest is a clock where a strobe updates the loops and the slot counter is 3, so the hold register loads in the same cycle. The hold register must take the signs from before the update. The bench provokes this coincidence by cycling the strobe period through 1, 3, 4 and 5 clocks while it sweeps every input value of an 8-bit configuration. It judges every output against an arithmetic model that captures the hold values before it applies the loop equations. Full-scale inputs drive the integrators into saturation in the same runs, and long constant-input runs check the long-term density.

// File: rtl/sdmx_pkg.sv
package sdmx_pkg;

   typedef logic [1:0] sym_t;

   localparam sym_t SYM_ZERO = 2'b00;
   localparam sym_t SYM_POS  = 2'b01;
   localparam sym_t SYM_NEG  = 2'b11;

   localparam int SLOT_W = 2;

   // map a stored sign (1 = negative) and a chop inversion to a symbol
   function automatic sym_t chop_sym(input logic is_neg, input logic invert);
      return (is_neg ^ invert) ? SYM_NEG : SYM_POS;
   endfunction

endpackage

// File: rtl/sdmx_lp_mod.sv
module sdmx_lp_mod #(
   parameter int IN_W      = 12,
   parameter int ACC_GUARD = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   stb,
   input  logic signed [IN_W-1:0] x,
   output logic                   neg
);
   localparam int AW = IN_W + ACC_GUARD;
   localparam int WW = AW + 2;
   localparam logic signed [WW-1:0] WMAX = WW'((2 ** (AW - 1)) - 1);
   localparam logic signed [WW-1:0] WMIN = -WMAX - WW'(1);
   localparam logic signed [WW-1:0] FBW  = WW'(2 ** (IN_W - 1));
   localparam logic signed [AW-1:0] STEP_LIM = AW'(2 ** IN_W);

   if (IN_W < 4) begin : g_bad_width
      $error("sdmx_lp_mod: IN_W must be at least 4");
   end
   if (ACC_GUARD < 2) begin : g_bad_guard
      $error("sdmx_lp_mod: ACC_GUARD must be at least 2");
   end

   logic signed [AW-1:0] a1_q, a2_q, a1_n, a2_n;
   logic signed [WW-1:0] x_w, fb_w, s1, s2;

   function automatic logic signed [AW-1:0] clip(input logic signed [WW-1:0] s);
      if (s > WMAX)      return WMAX[AW-1:0];
      else if (s < WMIN) return WMIN[AW-1:0];
      else               return s[AW-1:0];
   endfunction

   assign neg  = a2_q[AW-1];
   assign x_w  = {{(WW - IN_W){x[IN_W-1]}}, x};
   assign fb_w = neg ? -FBW : FBW;

   always_comb begin
      s1   = {{2{a1_q[AW-1]}}, a1_q} + x_w - fb_w;
      a1_n = clip(s1);
      s2   = {{2{a2_q[AW-1]}}, a2_q} + {{2{a1_n[AW-1]}}, a1_n} - fb_w;
      a2_n = clip(s2);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a1_q <= '0;
         a2_q <= '0;
      end else if (stb) begin
         a1_q <= a1_n;
         a2_q <= a2_n;
      end
   end

   // R5: state frozen without a strobe
   a_r5_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> ($stable(a1_q) && $stable(a2_q)));

   // R4: a non-negative first integrator cannot jump to a large negative value (no wrap)
   a_r4_no_wrap_pos: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && !a1_q[AW-1]) |=> (a1_q >= -STEP_LIM));

   // R4: a negative first integrator cannot jump to a large positive value
   a_r4_no_wrap_neg: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && a1_q[AW-1]) |=> (a1_q <= STEP_LIM));

endmodule

// File: rtl/sdmx_chop.sv
module sdmx_chop
   import sdmx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic neg_i,
   input  logic neg_q,
   output logic [1:0] sym
);
   logic [SLOT_W-1:0] slot_q, oslot_q;
   logic              hold_ni, hold_nq;
   sym_t              pick;

   always_comb begin
      unique case (slot_q)
         2'd0:    pick = chop_sym(hold_ni, 1'b0);
         2'd1:    pick = chop_sym(hold_nq, 1'b0);
         2'd2:    pick = chop_sym(hold_ni, 1'b1);
         default: pick = chop_sym(hold_nq, 1'b1);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q  <= '0;
         oslot_q <= '0;
         hold_ni <= 1'b0;
         hold_nq <= 1'b0;
         sym     <= SYM_ZERO;
      end else begin
         slot_q  <= slot_q + 1'b1;
         oslot_q <= slot_q;
         sym     <= pick;
         if (slot_q == 2'd3) begin
            hold_ni <= neg_i;
            hold_nq <= neg_q;
         end
      end
   end

   // R1: illegal code never produced
   a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      sym != 2'b10);

   // R6: hold register changes only after a slot-3 clock
   a_r6_hold_at_slot3: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_q != 2'd3) |=> ($stable(hold_ni) && $stable(hold_nq)));

   // R7: in-phase slots of one period carry opposite polarity
   a_r7_i_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (oslot_q == 2'd2 && sym != SYM_ZERO) |-> (sym[1] != $past(sym[1], 2)));

   // R7: quadrature slots of one period carry opposite polarity
   a_r7_q_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (oslot_q == 2'd3 && sym != SYM_ZERO) |-> (sym[1] != $past(sym[1], 2)));

endmodule

// File: rtl/sdmx_upconv.sv
module sdmx_upconv #(
   parameter int IN_W      = 12,
   parameter int ACC_GUARD = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bb_stb,
   input  logic signed [IN_W-1:0] bb_i,
   input  logic signed [IN_W-1:0] bb_q,
   output logic [1:0]             rf_sym
);
   localparam int NBR = 2;

   logic signed [IN_W-1:0] bb_x [NBR];
   logic [NBR-1:0]         br_neg;

   assign bb_x[0] = bb_i;
   assign bb_x[1] = bb_q;

   for (genvar b = 0; b < NBR; b++) begin : g_branch
      sdmx_lp_mod #(
         .IN_W      (IN_W),
         .ACC_GUARD (ACC_GUARD)
      ) i_mod (
         .clk   (clk),
         .rst_n (rst_n),
         .stb   (bb_stb),
         .x     (bb_x[b]),
         .neg   (br_neg[b])
      );
   end

   sdmx_chop i_chop (
      .clk   (clk),
      .rst_n (rst_n),
      .neg_i (br_neg[0]),
      .neg_q (br_neg[1]),
      .sym   (rf_sym)
   );

endmodule

// File: tb/test_sdmx_upconv.sv
module test_sdmx_upconv;
   localparam int IN_W = 8;
   localparam int GUARD = 2;
   localparam int AW = IN_W + GUARD;
   localparam int FB = 2 ** (IN_W - 1);
   localparam int AMAX = 2 ** (AW - 1) - 1;
   localparam int AMIN = -(2 ** (AW - 1));

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bb_stb = 1'b0;
   logic signed [IN_W-1:0] bb_i = '0, bb_q = '0;
   logic [1:0] rf_sym;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   // reference state
   int m1 [2], m2 [2];
   bit mh [2];
   int mslot;
   int cnt_on = 0, cnt_ip = 0, cnt_qp = 0;

   always #2.5 clk = ~clk;

   sdmx_upconv #(.IN_W(IN_W), .ACC_GUARD(GUARD)) i_sdmx_upconv (
      .clk(clk), .rst_n(rst_n), .bb_stb(bb_stb),
      .bb_i(bb_i), .bb_q(bb_q), .rf_sym(rf_sym));

   function automatic int clip(input int s);
      if (s > AMAX) return AMAX;
      if (s < AMIN) return AMIN;
      return s;
   endfunction

   function automatic logic [1:0] code(input bit is_neg);
      return is_neg ? 2'b11 : 2'b01;
   endfunction

   task automatic model_reset();
      for (int b = 0; b < 2; b++) begin
         m1[b] = 0; m2[b] = 0; mh[b] = 0;
      end
      mslot = 0;
   endtask

   task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s slot-cycle check: got %b expected %b", req, got, exp);
      end
   endtask

   // one fast clock: drive at negedge, model at posedge, compare at next negedge
   task automatic cyc(input bit stb, input int xi, input int xq);
      logic [1:0] e;
      int x [2];
      int v, n1;
      int sl;
      bb_stb = stb;
      bb_i = IN_W'(xi);
      bb_q = IN_W'(xq);
      x[0] = xi; x[1] = xq;
      @(posedge clk);
      sl = mslot;
      case (mslot)
         0: e = code(mh[0]);
         1: e = code(mh[1]);
         2: e = code(!mh[0]);
         default: e = code(!mh[1]);
      endcase
      if (mslot == 3) begin            // R6: capture before any same-cycle update
         for (int b = 0; b < 2; b++) mh[b] = (m2[b] < 0);
      end
      if (stb) begin                   // R3, R4, R5
         for (int b = 0; b < 2; b++) begin
            v = (m2[b] < 0) ? -FB : FB;
            n1 = clip(m1[b] + x[b] - v);
            m2[b] = clip(m2[b] + n1 - v);
            m1[b] = n1;
         end
      end
      mslot = (mslot + 1) % 4;
      @(negedge clk);
      check("R2/R3", rf_sym, e);
      if (cnt_on != 0) begin
         if (sl == 0 && rf_sym == 2'b01) cnt_ip++;
         if (sl == 1 && rf_sym == 2'b01) cnt_qp++;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      bb_stb = 1'b0;
      repeat (3) @(negedge clk);
      check("R8", rf_sym, 2'b00);
      model_reset();
      rst_n = 1'b1;
   endtask

   task automatic density(input int xi, input int xq, input int lo_i, input int hi_i,
                          input int lo_q, input int hi_q);
      for (int c = 0; c < 160; c++) cyc((c % 4) == 1, xi, xq);
      cnt_ip = 0; cnt_qp = 0; cnt_on = 1;
      for (int c = 0; c < 1600; c++) cyc((c % 4) == 1, xi, xq);
      cnt_on = 0;
      n_run++;
      if (cnt_ip < lo_i || cnt_ip > hi_i) begin
         n_fail++;
         $display("FAIL R9 I density x=%0d: got %0d expected %0d..%0d", xi, cnt_ip, lo_i, hi_i);
      end
      n_run++;
      if (cnt_qp < lo_q || cnt_qp > hi_q) begin
         n_fail++;
         $display("FAIL R9 Q density x=%0d: got %0d expected %0d..%0d", xq, cnt_qp, lo_q, hi_q);
      end
   endtask

   initial begin
      int per [4] = '{1, 3, 4, 5};
      int p;
      model_reset();
      @(negedge clk);
      check("R8", rf_sym, 2'b00);
      do_reset();

      // R2: first period after reset carries +I,+Q,-I,-Q with reset signs (+1)
      cyc(0, 0, 0); check("R2", rf_sym, 2'b01);
      cyc(0, 0, 0); check("R2", rf_sym, 2'b01);
      cyc(0, 0, 0); check("R2", rf_sym, 2'b11);
      cyc(0, 0, 0); check("R7", rf_sym, 2'b11);

      // sweep every input value; strobe periods vary so strobes hit slot 3 (R6, R5)
      for (int k = 0; k < 256; k++) begin
         p = per[k % 4];
         for (int c = 0; c < 12; c++) cyc((c % p) == 0, k - 128, 127 - k);
      end

      // full-scale inputs push integrators into saturation (R4)
      for (int c = 0; c < 200; c++) cyc((c % 2) == 0, -128, 127);
      for (int c = 0; c < 200; c++) cyc((c % 3) == 0, 127, -128);
      for (int c = 0; c < 100; c++) cyc(1, -128, -128);

      // reset in mid-run restores the start state (R8)
      do_reset();
      cyc(1, 100, -100); check("R2", rf_sym, 2'b01);

      // long-term density (R9): 400 periods counted
      density(64, -64, 270, 330, 70, 130);
      density(0, 0, 170, 230, 170, 230);
      density(-96, 32, 25, 75, 220, 280);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(5ns * 150000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule